// File: doc/BRIEF.md
# Cross-Port Mailbox Interrupt Flags

This block sits beside a two-port RAM and gives each port a doorbell. Each port owns one mailbox word near the top of the address space. When the other port writes that word, the owner's interrupt goes active. When the owner reads the word back, the interrupt is withdrawn. The mailbox words stay ordinary RAM locations. The 8-bit message is whatever the writer stored there, and this block never touches data. It watches both ports' select, output-enable, write strobe, address and busy inputs, and it drives two active-low interrupt outputs.

Each flag is a two-state machine, `FLAG_IDLE` or `FLAG_PEND`, built once per port by a generate loop. The machine has the following transitions:

- `FLAG_IDLE` goes to `FLAG_PEND` on a qualified set.
- `FLAG_PEND` goes to `FLAG_IDLE` on a qualified clear with no set in the same cycle.
- A synchronous reset forces `FLAG_IDLE`.
- Otherwise the state holds.

The interrupt output is low exactly while the machine is in `FLAG_PEND`. A qualifying access is sampled on a rising clock edge, and the output shows its effect right after that edge.

Top module: `mbox_irq_top`

## Requirements
- R1: While `rst` is high at a rising edge, both flags return to idle, so `lf_irq_n` and `rt_irq_n` read 1 after that edge.
- R2: A right-port write (`rt_sel`=1, `rt_we`=1) to address 0xFFFE (all ones minus one) drives `lf_irq_n` to 0 after the edge that samples it.
- R3: A left-port read of 0xFFFE (`lf_sel`=1, `lf_oe`=1, with any value of `lf_we`) returns `lf_irq_n` to 1 after the edge that samples it.
- R4: A left-port write (`lf_sel`=1, `lf_we`=1) to address 0xFFFF (all ones) drives `rt_irq_n` to 0 after the edge that samples it.
- R5: A right-port read of 0xFFFF (`rt_sel`=1, `rt_oe`=1, with any value of `rt_we`) returns `rt_irq_n` to 1 after the edge that samples it.
- R6: A set or clear whose initiating port has its busy input at 1 leaves the affected flag unchanged.
- R7: When a qualified set and a qualified clear reach the same flag in one cycle, the flag ends up pending, with its output at 0.
- R8: Any other access leaves both flags unchanged. This covers a different address, a deasserted select, and a write by the owner to its own mailbox with `oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; accesses are sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lf_sel | input | 1 | Left port select, active high |
| lf_oe | input | 1 | Left port output enable, active high |
| lf_we | input | 1 | Left port write strobe, active high |
| lf_addr | input | ADDR_W | Left port address |
| lf_busy | input | 1 | Left port busy, active high; suppresses this port's actions |
| rt_sel | input | 1 | Right port select, active high |
| rt_oe | input | 1 | Right port output enable, active high |
| rt_we | input | 1 | Right port write strobe, active high |
| rt_addr | input | ADDR_W | Right port address |
| rt_busy | input | 1 | Right port busy, active high |
| lf_irq_n | output | 1 | Left interrupt, active low |
| rt_irq_n | output | 1 | Right interrupt, active low |

## Verification
The bench builds the block with its default 16-bit address width, which places the two mailboxes at 0xFFFE and 0xFFFF. Random addresses are drawn so that most land on one of the two mailboxes or on their immediate neighbours. This brings within reach the following cases:

- set and clear hitting the same flag in one cycle;
- busy-suppressed actions;
- near-miss addresses that differ only in the lowest bit.

A bench function predicts each flag from the requirements.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_e;

    typedef struct packed {
        logic sel;
        logic oe;
        logic we;
        logic busy;
    } port_ctl_t;
endpackage

// File: rtl/mbox_req_decode.sv
module mbox_req_decode
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] MBOX_ADDR = '1
) (
    input  port_ctl_t         writer_ctl,
    input  logic [ADDR_W-1:0] writer_addr,
    input  port_ctl_t         owner_ctl,
    input  logic [ADDR_W-1:0] owner_addr,
    output logic              set_req,
    output logic              clr_req
);
    logic writer_hit;
    logic owner_hit;

    always_comb begin
        writer_hit = (writer_addr == MBOX_ADDR);
        owner_hit  = (owner_addr == MBOX_ADDR);
        set_req    = writer_ctl.sel && writer_ctl.we && writer_hit && !writer_ctl.busy;
        clr_req    = owner_ctl.sel && owner_ctl.oe && owner_hit && !owner_ctl.busy;
    end
endmodule

// File: rtl/mbox_flag_fsm.sv
module mbox_flag_fsm
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic irq_n
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (set_req) state_d = FLAG_PEND;
            FLAG_PEND: if (clr_req && !set_req) state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= FLAG_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        irq_n = (state_q != FLAG_PEND);
    end
endmodule

// File: rtl/mbox_irq_top.sv
module mbox_irq_top
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lf_sel,
    input  logic              lf_oe,
    input  logic              lf_we,
    input  logic [ADDR_W-1:0] lf_addr,
    input  logic              lf_busy,
    input  logic              rt_sel,
    input  logic              rt_oe,
    input  logic              rt_we,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              rt_busy,
    output logic              lf_irq_n,
    output logic              rt_irq_n
);
    localparam int NPORT = 2;
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    port_ctl_t         ctl  [NPORT];
    logic [ADDR_W-1:0] addr [NPORT];
    logic [NPORT-1:0]  set_req;
    logic [NPORT-1:0]  clr_req;
    logic [NPORT-1:0]  irq_n;

    always_comb begin
        ctl[0]  = '{sel: lf_sel, oe: lf_oe, we: lf_we, busy: lf_busy};
        ctl[1]  = '{sel: rt_sel, oe: rt_oe, we: rt_we, busy: rt_busy};
        addr[0] = lf_addr;
        addr[1] = rt_addr;
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_flag
        localparam logic [ADDR_W-1:0] MBOX = TOP_ADDR - ADDR_W'(NPORT - 1 - i);

        mbox_req_decode #(
            .ADDR_W    (ADDR_W),
            .MBOX_ADDR (MBOX)
        ) u_dec (
            .writer_ctl  (ctl[NPORT-1-i]),
            .writer_addr (addr[NPORT-1-i]),
            .owner_ctl   (ctl[i]),
            .owner_addr  (addr[i]),
            .set_req     (set_req[i]),
            .clr_req     (clr_req[i])
        );

        mbox_flag_fsm u_fsm (
            .clk     (clk),
            .rst     (rst),
            .set_req (set_req[i]),
            .clr_req (clr_req[i]),
            .irq_n   (irq_n[i])
        );
    end

    assign lf_irq_n = irq_n[0];
    assign rt_irq_n = irq_n[1];
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              lf_sel,
    input logic              lf_oe,
    input logic              lf_we,
    input logic [ADDR_W-1:0] lf_addr,
    input logic              lf_busy,
    input logic              rt_sel,
    input logic              rt_oe,
    input logic              rt_we,
    input logic [ADDR_W-1:0] rt_addr,
    input logic              rt_busy,
    input logic              lf_irq_n,
    input logic              rt_irq_n
);
    localparam logic [ADDR_W-1:0] LF_BOX = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] RT_BOX = '1;

    logic lf_set, lf_clr, rt_set, rt_clr;
    assign lf_set = rt_sel && rt_we && rt_addr == LF_BOX && !rt_busy;
    assign lf_clr = lf_sel && lf_oe && lf_addr == LF_BOX && !lf_busy;
    assign rt_set = lf_sel && lf_we && lf_addr == RT_BOX && !lf_busy;
    assign rt_clr = rt_sel && rt_oe && rt_addr == RT_BOX && !rt_busy;

    // R2, R7
    a_r2_left_set: assert property (@(posedge clk) disable iff (rst)
        lf_set |=> !lf_irq_n);
    // R3
    a_r3_left_clear: assert property (@(posedge clk) disable iff (rst)
        (lf_clr && !lf_set) |=> lf_irq_n);
    // R4
    a_r4_right_set: assert property (@(posedge clk) disable iff (rst)
        rt_set |=> !rt_irq_n);
    // R5
    a_r5_right_clear: assert property (@(posedge clk) disable iff (rst)
        (rt_clr && !rt_set) |=> rt_irq_n);
    // R6, R8
    a_r8_left_hold: assert property (@(posedge clk) disable iff (rst)
        (!lf_set && !lf_clr) |=> $stable(lf_irq_n));
    a_r8_right_hold: assert property (@(posedge clk) disable iff (rst)
        (!rt_set && !rt_clr) |=> $stable(rt_irq_n));
endmodule

bind mbox_irq_top mbox_irq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mbox_irq_top_tb.sv
module mbox_irq_top_tb;
    localparam int AW = 16;
    localparam logic [AW-1:0] LBOX = 16'hFFFE;
    localparam logic [AW-1:0] RBOX = 16'hFFFF;

    logic clk = 0, rst = 1;
    logic lf_sel = 0, lf_oe = 0, lf_we = 0, lf_busy = 0;
    logic rt_sel = 0, rt_oe = 0, rt_we = 0, rt_busy = 0;
    logic [AW-1:0] lf_addr = '0, rt_addr = '0;
    logic lf_irq_n, rt_irq_n;
    int checks = 0, fails = 0;
    logic exp_l = 0, exp_r = 0;   // 1 = pending
    bit done = 0;

    always #5 clk = ~clk;

    mbox_irq_top #(.ADDR_W(AW)) u_dut (.*);

    function automatic logic next_flag(logic cur, logic set, logic clr);
        if (set) return 1'b1;
        if (clr) return 1'b0;
        return cur;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic idle();
        lf_sel = 0; lf_oe = 0; lf_we = 0; lf_busy = 0; lf_addr = '0;
        rt_sel = 0; rt_oe = 0; rt_we = 0; rt_busy = 0; rt_addr = '0;
    endtask

    // apply current inputs for one edge, update model, compare after edge
    task automatic step(string tag);
        logic ls, lc, rs, rc;
        ls = rt_sel && rt_we && rt_addr == LBOX && !rt_busy;
        lc = lf_sel && lf_oe && lf_addr == LBOX && !lf_busy;
        rs = lf_sel && lf_we && lf_addr == RBOX && !lf_busy;
        rc = rt_sel && rt_oe && rt_addr == RBOX && !rt_busy;
        if (rst) begin exp_l = 0; exp_r = 0; end
        else begin
            exp_l = next_flag(exp_l, ls, lc);
            exp_r = next_flag(exp_r, rs, rc);
        end
        @(posedge clk); #2;
        check({tag, " left"},  lf_irq_n, ~exp_l);
        check({tag, " right"}, rt_irq_n, ~exp_r);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #2;
        step("R1 reset");
        step("R1 reset");
        rst = 0;
        step("R8 idle");
        // R2 set left
        rt_sel = 1; rt_we = 1; rt_addr = LBOX; step("R2 set left"); idle();
        step("R8 hold");
        // R3 clear left with we=1 (don't care)
        lf_sel = 1; lf_oe = 1; lf_we = 1; lf_addr = LBOX; step("R3 clear left"); idle();
        // R4 set right
        lf_sel = 1; lf_we = 1; lf_addr = RBOX; step("R4 set right"); idle();
        // R6 busy blocks clear on right
        rt_sel = 1; rt_oe = 1; rt_addr = RBOX; rt_busy = 1; step("R6 busy clear"); idle();
        // R5 clear right
        rt_sel = 1; rt_oe = 1; rt_addr = RBOX; step("R5 clear right"); idle();
        // R6 busy blocks set
        rt_sel = 1; rt_we = 1; rt_addr = LBOX; rt_busy = 1; step("R6 busy set"); idle();
        // R8 owner writes own box without oe, neighbour address, no select
        lf_sel = 1; lf_we = 1; lf_addr = LBOX; step("R8 own write"); idle();
        rt_sel = 1; rt_we = 1; rt_addr = 16'hFFFD; step("R8 other addr"); idle();
        rt_we = 1; rt_addr = LBOX; step("R8 no select"); idle();
        // R7 set and clear together, from idle and from pending
        rt_sel = 1; rt_we = 1; rt_addr = LBOX;
        lf_sel = 1; lf_oe = 1; lf_addr = LBOX; step("R7 set wins"); step("R7 set wins again"); idle();
        // R1 reset while pending
        rst = 1; step("R1 reset pending"); rst = 0; idle();
        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] pick [4] = '{LBOX, RBOX, 16'hFFFD, 16'h0000};
            lf_sel = 1'($urandom); lf_oe = 1'($urandom); lf_we = 1'($urandom);
            lf_busy = ($urandom % 5) == 0;
            rt_sel = 1'($urandom); rt_oe = 1'($urandom); rt_we = 1'($urandom);
            rt_busy = ($urandom % 5) == 0;
            lf_addr = pick[$urandom % 4];
            rt_addr = ($urandom % 8 == 0) ? AW'($urandom) : pick[$urandom % 4];
            rst = ($urandom % 200) == 0;
            step("R8 random model");
        end
        rst = 0; idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule